// File: doc/BRIEF.md
# Segment access rights checker

This block screens a single memory access against a small cache of segment descriptors while the processor runs in protected mode. Each of the segments holds an 8-bit rights byte and a 16-bit limit. A request names a segment, a 16-bit offset, an access size of one or two bytes, and a kind of access: read, write or execute. One clock later the block answers with either a one-cycle pass pulse or a one-cycle general-protection fault pulse, which carries the fault vector 13.

Protected mode is selected by a level input. While it is low, every request passes with no check. While it is high, three checks run in a fixed order. The first asks whether the segment is present. The second asks whether the access stays inside the limit. The third applies the type rule for reads and writes. Execute requests skip the type rule. A separate write port loads the rights and limit of one segment per cycle. Loading descriptors from memory is left to the surrounding logic.

Top module: `seg_guard`

## Requirements
- R1: While reset is active, and after it is released with no request made, `ok_pulse` and `fault_pulse` are 0 and `fault_vec` is 0. Every cached rights byte and limit resets to 0, so each segment starts out not present.
- R2: With `prot_en` low, every request yields `ok_pulse` one cycle later, whatever the cached descriptor holds and whatever the offset.
- R3: With `prot_en` high, a request to a segment whose rights bit 7 (present) is 0 faults, for any access kind.
- R4: With `prot_en` high, a request faults when offset plus size, summed in 17 bits with no 16-bit wrap, is greater than the segment limit. Equality passes. Size code 1 is a byte and 2 is a word.
- R5: A read (`req_op` = 1) faults unless the segment is readable. A segment is readable when rights bit 3 is 0, or when bits 3 and 1 are both 1.
- R6: A write (`req_op` = 2) faults unless the rights byte ANDed with 0x0A equals 0x02.
- R7: An execute (`req_op` = 3) skips the read and write type rules, but it still faults on a missing present bit or a limit overrun.
- R8: A request in cycle N gives exactly one of `ok_pulse` or `fault_pulse` in cycle N+1, each high for one cycle. With no request, both stay low. The two are never high together.
- R9: `fault_vec` equals 13 in the cycle when `fault_pulse` is high, and 0 in every other cycle.
- R10: A write on the descriptor port updates only the segment it names, from the next cycle on. A request in the same cycle as a write to its own segment is judged against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Protected mode enable; low disables all checks |
| req_valid | input | 1 | Access request strobe |
| req_seg | input | 2 | Segment index of the request |
| req_off | input | 16 | Offset within the segment |
| req_size | input | 2 | Access size: 1 byte or 2 bytes |
| req_op | input | 2 | Access kind: 1 read, 2 write, 3 execute |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | 2 | Segment index to update |
| wr_rights | input | 8 | New rights byte |
| wr_limit | input | 16 | New limit |
| ok_pulse | output | 1 | One-cycle pass result |
| fault_pulse | output | 1 | One-cycle general-protection fault |
| fault_vec | output | 8 | Fault vector (13) while fault_pulse is high, else 0 |

## Verification
A descriptor update and an access check can land in the same cycle on the same segment. The bench provokes this by driving a write that clears the present bit of segment 3 in the same cycle as a write access to that segment. The result must be a pass, because the old descriptor was present and writable. A second access one cycle later must then fault with vector 13. A write to a different segment, sent in the same cycle as a request, must leave the requested segment's verdict unchanged.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  localparam int unsigned RIGHTS_W    = 8;
  localparam int unsigned PRESENT_BIT = 7;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_op_e;

  typedef enum logic [2:0] {
    CHK_PASS    = 3'd0,
    CHK_ABSENT  = 3'd1,
    CHK_LIMIT   = 3'd2,
    CHK_NOREAD  = 3'd3,
    CHK_NOWRITE = 3'd4
  } chk_cause_e;

  // Data segments are readable; code segments only when their read bit is set.
  function automatic logic rights_readable(input logic [RIGHTS_W-1:0] r);
    return (r[3] == 1'b0) || (r[3] && r[1]);
  endfunction

  // Only a data segment with its write bit set accepts stores.
  function automatic logic rights_writable(input logic [RIGHTS_W-1:0] r);
    return (r & 8'h0A) == 8'h02;
  endfunction

endpackage

// File: rtl/seg_guard_store.sv
module seg_guard_store
  import seg_guard_pkg::*;
#(
  parameter int unsigned NSEG  = 4,
  parameter int unsigned LIM_W = 16,
  localparam int unsigned SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEG_W-1:0]         wr_seg,
  input  logic [RIGHTS_W-1:0]      wr_rights,
  input  logic [LIM_W-1:0]         wr_limit,
  output logic [NSEG*RIGHTS_W-1:0] rights_flat,
  output logic [NSEG*LIM_W-1:0]    limit_flat
);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic                hit;
    logic [RIGHTS_W-1:0] rights_q, rights_d;
    logic [LIM_W-1:0]    limit_q, limit_d;

    assign hit = wr_en && (wr_seg == SEG_W'(g));

    always_comb begin
      rights_d = wr_rights;
      limit_d  = wr_limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rights_q <= '0;
        limit_q  <= '0;
      end else if (hit) begin
        rights_q <= rights_d;
        limit_q  <= limit_d;
      end
    end

    assign rights_flat[g*RIGHTS_W +: RIGHTS_W] = rights_q;
    assign limit_flat[g*LIM_W +: LIM_W]        = limit_q;
  end

endmodule

// File: rtl/seg_guard_eval.sv
module seg_guard_eval
  import seg_guard_pkg::*;
#(
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned SIZE_W = 2
) (
  input  logic                prot_en,
  input  logic [RIGHTS_W-1:0] rights,
  input  logic [LIM_W-1:0]    limit,
  input  logic [LIM_W-1:0]    off,
  input  logic [SIZE_W-1:0]   size,
  input  acc_op_e             op,
  output chk_cause_e          cause
);

  localparam int unsigned SUM_W = LIM_W + 1;

  logic [SUM_W-1:0] end_pos;
  logic             over_limit;

  // The sum is one bit wider than the offset, so an access that runs past 0xFFFF does not wrap.
  assign end_pos    = {1'b0, off} + {{(SUM_W-SIZE_W){1'b0}}, size};
  assign over_limit = end_pos > {1'b0, limit};

  // Checks in priority order: present, then limit, then type.
  always_comb begin
    cause = CHK_PASS;
    if (prot_en) begin
      if (!rights[PRESENT_BIT]) begin
        cause = CHK_ABSENT;
      end else if (over_limit) begin
        cause = CHK_LIMIT;
      end else begin
        unique case (op)
          ACC_READ:  if (!rights_readable(rights)) cause = CHK_NOREAD;
          ACC_WRITE: if (!rights_writable(rights)) cause = CHK_NOWRITE;
          default:   cause = CHK_PASS;
        endcase
      end
    end
  end

endmodule

// File: rtl/seg_guard_verdict.sv
module seg_guard_verdict
  import seg_guard_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned FAULT_VEC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  chk_cause_e       cause,
  output logic             ok_pulse,
  output logic             fault_pulse,
  output logic [VEC_W-1:0] fault_vec
);

  logic             ok_d, fault_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    ok_d    = req_valid && (cause == CHK_PASS);
    fault_d = req_valid && (cause != CHK_PASS);
    vec_d   = fault_d ? VEC_W'(FAULT_VEC) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_pulse    <= 1'b0;
      fault_pulse <= 1'b0;
      fault_vec   <= '0;
    end else begin
      ok_pulse    <= ok_d;
      fault_pulse <= fault_d;
      fault_vec   <= vec_d;
    end
  end

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int unsigned NSEG      = 4,
  parameter int unsigned LIM_W     = 16,
  parameter int unsigned SIZE_W    = 2,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned FAULT_VEC = 13,
  localparam int unsigned SEG_W    = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prot_en,
  input  logic                req_valid,
  input  logic [SEG_W-1:0]    req_seg,
  input  logic [LIM_W-1:0]    req_off,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [1:0]          req_op,
  input  logic                wr_en,
  input  logic [SEG_W-1:0]    wr_seg,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic [LIM_W-1:0]    wr_limit,
  output logic                ok_pulse,
  output logic                fault_pulse,
  output logic [VEC_W-1:0]    fault_vec
);

  // The reset asserts at once and releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSEG*RIGHTS_W-1:0] rights_flat;
  logic [NSEG*LIM_W-1:0]    limit_flat;
  logic [RIGHTS_W-1:0]      sel_rights;
  logic [LIM_W-1:0]         sel_limit;
  chk_cause_e               cause;

  seg_guard_store #(.NSEG(NSEG), .LIM_W(LIM_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wr_en),
    .wr_seg      (wr_seg),
    .wr_rights   (wr_rights),
    .wr_limit    (wr_limit),
    .rights_flat (rights_flat),
    .limit_flat  (limit_flat)
  );

  // Reads the registered descriptor, so a write in this cycle is not seen yet.
  assign sel_rights = rights_flat[req_seg*RIGHTS_W +: RIGHTS_W];
  assign sel_limit  = limit_flat[req_seg*LIM_W +: LIM_W];

  seg_guard_eval #(.LIM_W(LIM_W), .SIZE_W(SIZE_W)) u_eval (
    .prot_en (prot_en),
    .rights  (sel_rights),
    .limit   (sel_limit),
    .off     (req_off),
    .size    (req_size),
    .op      (acc_op_e'(req_op)),
    .cause   (cause)
  );

  seg_guard_verdict #(.VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_verdict (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .cause       (cause),
    .ok_pulse    (ok_pulse),
    .fault_pulse (fault_pulse),
    .fault_vec   (fault_vec)
  );

endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int unsigned NSEG      = 4,
  parameter int unsigned LIM_W     = 16,
  parameter int unsigned SIZE_W    = 2,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned FAULT_VEC = 13,
  parameter int unsigned SEG_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 prot_en,
  input logic                 req_valid,
  input logic [SEG_W-1:0]     req_seg,
  input logic [LIM_W-1:0]     req_off,
  input logic [SIZE_W-1:0]    req_size,
  input logic [1:0]           req_op,
  input logic [NSEG*8-1:0]    cur_rights,
  input logic [NSEG*LIM_W-1:0] cur_limit,
  input logic                 ok_pulse,
  input logic                 fault_pulse,
  input logic [VEC_W-1:0]     fault_vec
);

  logic [7:0]       c_rights;
  logic [LIM_W-1:0] c_limit;
  logic [LIM_W:0]   c_end;

  assign c_rights = cur_rights[req_seg*8 +: 8];
  assign c_limit  = cur_limit[req_seg*LIM_W +: LIM_W];
  assign c_end    = {1'b0, req_off} + {{(LIM_W+1-SIZE_W){1'b0}}, req_size};

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_pulse && fault_pulse));

  // R8
  answer_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (ok_pulse || fault_pulse));

  // R8
  no_unasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(ok_pulse || fault_pulse));

  // R2
  real_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> ok_pulse);

  // R3
  absent_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_en && !c_rights[7]) |=> fault_pulse);

  // R4
  limit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_en && (c_end > {1'b0, c_limit})) |=> fault_pulse);

  // R6
  write_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_en && req_op == 2'd2 && (c_rights & 8'h0A) != 8'h02) |=> fault_pulse);

  // R9
  vec_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (fault_vec == VEC_W'(FAULT_VEC)));

  // R9
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse |-> (fault_vec == '0));

endmodule

bind seg_guard seg_guard_chk #(
  .NSEG(NSEG), .LIM_W(LIM_W), .SIZE_W(SIZE_W), .VEC_W(VEC_W),
  .FAULT_VEC(FAULT_VEC), .SEG_W(SEG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .prot_en     (prot_en),
  .req_valid   (req_valid),
  .req_seg     (req_seg),
  .req_off     (req_off),
  .req_size    (req_size),
  .req_op      (req_op),
  .cur_rights  (rights_flat),
  .cur_limit   (limit_flat),
  .ok_pulse    (ok_pulse),
  .fault_pulse (fault_pulse),
  .fault_vec   (fault_vec)
);

// File: tb/seg_guard_bench.sv
module seg_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prot_en;
  logic        req_valid;
  logic [1:0]  req_seg;
  logic [15:0] req_off;
  logic [1:0]  req_size;
  logic [1:0]  req_op;
  logic        wr_en;
  logic [1:0]  wr_seg;
  logic [7:0]  wr_rights;
  logic [15:0] wr_limit;
  logic        ok_pulse, fault_pulse;
  logic [7:0]  fault_vec;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  localparam int RD = 1, WR = 2, EX = 3;

  always #5 clk = ~clk;

  seg_guard u_seg_guard (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .req_valid(req_valid),
    .req_seg(req_seg), .req_off(req_off), .req_size(req_size), .req_op(req_op),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_rights(wr_rights), .wr_limit(wr_limit),
    .ok_pulse(ok_pulse), .fault_pulse(fault_pulse), .fault_vec(fault_vec)
  );

  task automatic judge(input string tag, input bit exp_ok, input bit exp_fault);
    logic [7:0] exp_vec;
    exp_vec = exp_fault ? 8'd13 : 8'd0;
    checks++;
    if (ok_pulse !== exp_ok || fault_pulse !== exp_fault || fault_vec !== exp_vec) begin
      failures++;
      $display("FAIL %s: ok=%0b fault=%0b vec=%0d expected ok=%0b fault=%0b vec=%0d",
               tag, ok_pulse, fault_pulse, fault_vec, exp_ok, exp_fault, exp_vec);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic load(input int s, input logic [7:0] r, input logic [15:0] l);
    wr_en = 1'b1; wr_seg = s[1:0]; wr_rights = r; wr_limit = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input string tag, input int s, input int off, input int size,
                        input int op, input bit exp_fault);
    req_valid = 1'b1; req_seg = s[1:0]; req_off = off[15:0];
    req_size = size[1:0]; req_op = op[1:0];
    @(negedge clk);
    req_valid = 1'b0;
    judge(tag, !exp_fault, exp_fault);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; prot_en = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0;
    req_size = 2'd1; req_op = 2'd1; wr_en = 1'b0; wr_seg = '0; wr_rights = '0; wr_limit = '0;
    repeat (3) @(negedge clk);
    judge("R1 during reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    judge("R1 after release", 1'b0, 1'b0);
  endtask

  task automatic t_real_mode;
    prot_en = 1'b0;
    access("R2 absent seg passes", 0, 16'h0000, 1, RD, 1'b0);
    access("R2 high offset word write", 1, 16'hFFFF, 2, WR, 1'b0);
    prot_en = 1'b1;
    access("R1 reset descriptor not present", 2, 0, 1, EX, 1'b1);
  endtask

  task automatic t_absent;
    load(1, 8'h12, 16'hFFFF);
    access("R3 absent read", 1, 16'h0010, 1, RD, 1'b1);
    access("R3 absent execute", 1, 16'h0010, 1, EX, 1'b1);
    access("R3 absent over limit", 1, 16'hFFFF, 2, WR, 1'b1);
  endtask

  task automatic t_limit;
    load(2, 8'h92, 16'h0100);
    access("R4 end equals limit", 2, 16'h00FF, 1, RD, 1'b0);
    access("R4 word crosses limit", 2, 16'h00FF, 2, RD, 1'b1);
    access("R4 byte past limit", 2, 16'h0100, 1, WR, 1'b1);
    load(2, 8'h92, 16'hFFFF);
    access("R4 top byte fits", 2, 16'hFFFE, 1, RD, 1'b0);
    access("R4 no 16-bit wrap", 2, 16'hFFFE, 2, RD, 1'b1);
  endtask

  task automatic t_read;
    load(0, 8'h90, 16'hFFFF);
    access("R5 data segment read", 0, 16'h0040, 2, RD, 1'b0);
    load(0, 8'h98, 16'hFFFF);
    access("R5 execute-only read", 0, 16'h0040, 2, RD, 1'b1);
    load(0, 8'h9A, 16'hFFFF);
    access("R5 readable code read", 0, 16'h0040, 1, RD, 1'b0);
  endtask

  task automatic t_write;
    load(0, 8'h92, 16'hFFFF);
    access("R6 writable data", 0, 16'h0080, 2, WR, 1'b0);
    load(0, 8'h90, 16'hFFFF);
    access("R6 read-only data", 0, 16'h0080, 2, WR, 1'b1);
    load(0, 8'h9A, 16'hFFFF);
    access("R6 code segment write", 0, 16'h0080, 1, WR, 1'b1);
  endtask

  task automatic t_exec;
    load(3, 8'h98, 16'h0020);
    access("R7 execute-only code", 3, 16'h0010, 2, EX, 1'b0);
    access("R7 exec over limit", 3, 16'h0020, 1, EX, 1'b1);
    load(3, 8'h90, 16'h0020);
    access("R7 exec on read-only data", 3, 16'h0000, 1, EX, 1'b0);
  endtask

  task automatic t_pulse;
    load(1, 8'h12, 16'h0000);
    access("R8 fault pulse", 1, 16'hFFFF, 2, RD, 1'b1);
    @(negedge clk);
    judge("R8 fault lasts one cycle", 1'b0, 1'b0);
    access("R8 pass pulse", 3, 0, 1, EX, 1'b0);
    repeat (3) @(negedge clk);
    judge("R8 idle without request", 1'b0, 1'b0);
  endtask

  task automatic t_collision;
    load(3, 8'h92, 16'hFFFF);
    wr_en = 1'b1; wr_seg = 2'd3; wr_rights = 8'h12; wr_limit = 16'hFFFF;
    access("R10 same-cycle write uses old", 3, 16'h0004, 2, WR, 1'b0);
    wr_en = 1'b0;
    access("R10 new contents next cycle", 3, 16'h0004, 2, WR, 1'b1);
    load(0, 8'h92, 16'hFFFF);
    wr_en = 1'b1; wr_seg = 2'd2; wr_rights = 8'h00; wr_limit = 16'h0000;
    access("R10 other segment untouched", 0, 16'h0004, 2, WR, 1'b0);
    wr_en = 1'b0;
    access("R10 other segment still intact", 0, 16'h0004, 2, RD, 1'b0);
  endtask

  initial begin
    t_reset();
    t_real_mode();
    t_absent();
    t_limit();
    t_read();
    t_write();
    t_exec();
    t_pulse();
    t_collision();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule